// File: doc/BRIEF.md
# Flash Page Layout Interleaver

This block walks the physical byte order of one flash page and tells, for every physical byte, where that byte lives in the logical view of the page. The logical view has a data buffer made of equal packets and a spare area. The spare area holds a 6-byte bad-block marker region at offsets 0 to 5 and 4 metadata bytes at offsets 6 to 9. These are followed by the ECC bytes of each step, with step k at 10 + k*E. On flash, the metadata comes first, then each packet followed by its ECC bytes. The marker region sits at the physical offset equal to the page size, so it cuts the last packet in two.

A controller issues a start pulse with the page size, packet size, ECC bytes per step and two enables. The block then emits one beat per physical byte under a valid/ready handshake. Each beat carries the physical position, a source tag, the logical index, and a flag on the final byte. The same sequence serves writes (the index selects the byte to send) and reads (the index selects the slot to fill). When a side has no buffer, for example a spare-only access with the data side disabled, its beats are tagged skip: the position still advances but no transfer is implied.

Top module: `pgl_interleaver`

## Requirements
- R1: One cycle after a start pulse, out_valid is high with out_pos 0. out_pos then rises by one for every accepted beat. Sizes and enables are captured at start, and changes on those inputs later in the sequence have no effect.
- R2: Positions 0 to 3 are spare beats (tag 1) with indices 6 to 9.
- R3: A packet is a full packet when the bytes left before the page-size offset at its start exceed the packet size P. It emits P data beats (tag 0) with indices k*P to k*P+P-1, then E spare beats with indices 10+k*E upward.
- R4: The marker occupies positions page to page+5 as spare beats with indices 0 to 5, and it appears exactly once per page.
- R5: The final packet emits data beats up to the page-size offset, then the marker, then the rest of the packet, then its E ECC beats. Its data indices continue without a gap across the marker.
- R6: out_last is high only on the final ECC beat. After that beat is accepted, out_valid stays low until the next start.
- R7: With the data enable low, data beats carry tag 2 (skip). With the spare enable low, spare beats carry tag 2. Positions and indices do not change.
- R8: While out_valid is high and out_ready is low, the beat on the outputs holds stable.
- R9: A start during a sequence abandons it and begins again at position 0 with the newly captured configuration.
- R10: During reset and after it, until the first start, out_valid and out_last are low.
- R11: A final packet that starts exactly P bytes before the page-size offset goes data, marker, ECC. One that starts at the offset itself begins with the marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new page walk; captures the configuration |
| page_bytes | input | POS_W | Page size in bytes (offset of the marker region) |
| pkt_bytes | input | POS_W | Data bytes per ECC step |
| ecc_bytes | input | ECC_W | ECC bytes per step, at least 1 |
| data_en | input | 1 | Data side has a buffer; low tags data beats as skip |
| spare_en | input | 1 | Spare side has a buffer; low tags spare beats as skip |
| out_ready | input | 1 | Consumer accepts the current beat |
| out_valid | output | 1 | A beat is presented |
| out_pos | output | POS_W | Physical byte position in the page |
| out_tag | output | 2 | 0 data, 1 spare, 2 skip |
| out_idx | output | POS_W | Index in the data buffer or spare area |
| out_last | output | 1 | Final byte of the page |

## Verification
Most wrong internal states appear on the very next accepted beat. A packet counter that is off by one moves an ECC run by a byte. A wrong ECC base shifts the spare index of every later step. A missed or repeated marker entry pushes every later position out of step with its index. Because each beat is compared with an independently computed expected sequence, such a fault is reported at the first byte that differs, and not only at the end of the page. Errors in the state that ends the sequence show up in the last flag or in a valid that stays high after the final beat. Stalls are checked one cycle after each refused beat.

// File: rtl/pgl_pkg.sv
package pgl_pkg;

  localparam int META_LEN        = 4;
  localparam int MARK_LEN        = 6;
  localparam int META_SPARE_BASE = MARK_LEN;
  localparam int ECC_SPARE_BASE  = MARK_LEN + META_LEN;

  typedef enum logic [1:0] {
    TAG_DATA  = 2'd0,
    TAG_SPARE = 2'd1,
    TAG_SKIP  = 2'd2
  } beat_tag_e;

  typedef enum logic [2:0] {
    SEG_IDLE = 3'd0,
    SEG_META = 3'd1,
    SEG_DATA = 3'd2,
    SEG_MARK = 3'd3,
    SEG_ECC  = 3'd4
  } seg_e;

  // A packet starting at start_pos is the one split by the marker when no
  // more than one packet's worth of bytes remains before the page offset.
  function automatic logic packet_reaches_page(input logic [31:0] start_pos,
                                               input logic [31:0] pkt_len,
                                               input logic [31:0] page_len);
    return (start_pos + pkt_len) >= page_len;
  endfunction

  // Spare-area slot of a byte in one of the spare segments.
  function automatic logic [31:0] spare_slot(input seg_e seg,
                                             input logic [31:0] cnt,
                                             input logic [31:0] ecc_base);
    logic [31:0] slot;
    case (seg)
      SEG_META: slot = 32'(META_SPARE_BASE) + cnt;
      SEG_MARK: slot = cnt;
      SEG_ECC:  slot = ecc_base + cnt;
      default:  slot = '0;
    endcase
    return slot;
  endfunction

endpackage

// File: rtl/pgl_cfg_hold.sv
module pgl_cfg_hold #(
  parameter int POS_W = 16,
  parameter int ECC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [POS_W-1:0] page_in,
  input  logic [POS_W-1:0] pkt_in,
  input  logic [ECC_W-1:0] ecc_in,
  input  logic             data_en_in,
  input  logic             spare_en_in,
  output logic [POS_W-1:0] page_q,
  output logic [POS_W-1:0] pkt_q,
  output logic [ECC_W-1:0] ecc_q,
  output logic             data_en_q,
  output logic             spare_en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q     <= '0;
      pkt_q      <= '0;
      ecc_q      <= '0;
      data_en_q  <= 1'b0;
      spare_en_q <= 1'b0;
    end else if (start) begin
      page_q     <= page_in;
      pkt_q      <= pkt_in;
      ecc_q      <= ecc_in;
      data_en_q  <= data_en_in;
      spare_en_q <= spare_en_in;
    end
  end

endmodule

// File: rtl/pgl_cursor.sv
module pgl_cursor
  import pgl_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int ECC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             advance,
  input  logic [POS_W-1:0] page_len,
  input  logic [POS_W-1:0] pkt_len,
  input  logic [ECC_W-1:0] ecc_len,
  output seg_e             seg,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] dcnt,
  output logic [POS_W-1:0] didx,
  output logic [POS_W-1:0] ecc_base,
  output logic [ECC_W-1:0] scnt,
  output logic             final_pkt,
  output logic             mark_done
);

  localparam logic [POS_W-1:0] POS_ONE   = POS_W'(1);
  localparam logic [ECC_W-1:0] CNT_ONE   = ECC_W'(1);
  localparam logic [ECC_W-1:0] META_LAST = ECC_W'(META_LEN - 1);
  localparam logic [ECC_W-1:0] MARK_LAST = ECC_W'(MARK_LEN - 1);

  // Named internal events
  logic [POS_W-1:0] pos_nx;
  logic             page_hit;
  logic             next_is_final;
  logic             meta_end;
  logic             mark_end;
  logic             ecc_end;
  logic             pkt_full_nx;
  logic             split_now;
  seg_e             data_entry;

  assign pos_nx        = pos + POS_ONE;
  assign page_hit      = (pos_nx == page_len);
  assign next_is_final = packet_reaches_page(32'(pos_nx), 32'(pkt_len), 32'(page_len));
  assign meta_end      = (scnt == META_LAST);
  assign mark_end      = (scnt == MARK_LAST);
  assign ecc_end       = (scnt == (ecc_len - CNT_ONE));
  assign pkt_full_nx   = ((dcnt + POS_ONE) == pkt_len);
  assign split_now     = final_pkt && !mark_done && page_hit;
  assign data_entry    = (next_is_final && page_hit) ? SEG_MARK : SEG_DATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg       <= SEG_IDLE;
      pos       <= '0;
      dcnt      <= '0;
      didx      <= '0;
      ecc_base  <= '0;
      scnt      <= '0;
      final_pkt <= 1'b0;
      mark_done <= 1'b0;
    end else if (start) begin
      seg       <= SEG_META;
      pos       <= '0;
      dcnt      <= '0;
      didx      <= '0;
      ecc_base  <= POS_W'(ECC_SPARE_BASE);
      scnt      <= '0;
      final_pkt <= 1'b0;
      mark_done <= 1'b0;
    end else if (advance) begin
      pos <= pos_nx;
      case (seg)
        SEG_META: begin
          if (meta_end) begin
            scnt      <= '0;
            dcnt      <= '0;
            final_pkt <= next_is_final;
            seg       <= data_entry;
          end else begin
            scnt <= scnt + CNT_ONE;
          end
        end
        SEG_DATA: begin
          dcnt <= dcnt + POS_ONE;
          didx <= didx + POS_ONE;
          if (split_now) begin
            scnt <= '0;
            seg  <= SEG_MARK;
          end else if (pkt_full_nx) begin
            scnt <= '0;
            seg  <= SEG_ECC;
          end
        end
        SEG_MARK: begin
          if (mark_end) begin
            scnt      <= '0;
            mark_done <= 1'b1;
            seg       <= (dcnt == pkt_len) ? SEG_ECC : SEG_DATA;
          end else begin
            scnt <= scnt + CNT_ONE;
          end
        end
        SEG_ECC: begin
          if (ecc_end) begin
            scnt <= '0;
            if (final_pkt) begin
              seg <= SEG_IDLE;
            end else begin
              dcnt      <= '0;
              ecc_base  <= ecc_base + POS_W'(ecc_len);
              final_pkt <= next_is_final;
              seg       <= data_entry;
            end
          end else begin
            scnt <= scnt + CNT_ONE;
          end
        end
        default: seg <= SEG_IDLE;
      endcase
    end
  end

  // Position moves by exactly one per accepted beat
  assert_pos_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !start |=> pos == $past(pos) + POS_ONE);

  // Metadata occupies the first physical bytes in order
  assert_meta_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seg == SEG_META |-> pos == POS_W'(scnt));

  // The marker region opens exactly at the page-size offset
  assert_mark_at_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seg == SEG_MARK && scnt == '0 |-> pos == page_len);

  // The marker belongs to the final packet and is never entered twice
  assert_mark_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seg == SEG_MARK |-> final_pkt && !mark_done);

  // A start always rewinds to the metadata at position zero
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> seg == SEG_META && pos == '0);

endmodule

// File: rtl/pgl_beat_map.sv
module pgl_beat_map
  import pgl_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int ECC_W = 8
) (
  input  seg_e             seg,
  input  logic [POS_W-1:0] didx,
  input  logic [POS_W-1:0] ecc_base,
  input  logic [ECC_W-1:0] scnt,
  input  logic [ECC_W-1:0] ecc_len,
  input  logic             final_pkt,
  input  logic             data_en,
  input  logic             spare_en,
  output logic [1:0]       tag,
  output logic [POS_W-1:0] idx,
  output logic             last
);

  logic is_data;
  logic is_spare;
  logic [31:0] slot;

  assign is_data  = (seg == SEG_DATA);
  assign is_spare = (seg == SEG_META) || (seg == SEG_MARK) || (seg == SEG_ECC);
  assign slot     = spare_slot(seg, 32'(scnt), 32'(ecc_base));

  always_comb begin
    tag = TAG_SKIP;
    idx = '0;
    if (is_data) begin
      tag = data_en ? TAG_DATA : TAG_SKIP;
      idx = didx;
    end else if (is_spare) begin
      tag = spare_en ? TAG_SPARE : TAG_SKIP;
      idx = slot[POS_W-1:0];
    end
  end

  assign last = (seg == SEG_ECC) && final_pkt && (scnt == (ecc_len - ECC_W'(1)));

endmodule

// File: rtl/pgl_interleaver.sv
module pgl_interleaver
  import pgl_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int ECC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [POS_W-1:0] page_bytes,
  input  logic [POS_W-1:0] pkt_bytes,
  input  logic [ECC_W-1:0] ecc_bytes,
  input  logic             data_en,
  input  logic             spare_en,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [POS_W-1:0] out_pos,
  output logic [1:0]       out_tag,
  output logic [POS_W-1:0] out_idx,
  output logic             out_last
);

  logic [POS_W-1:0] page_q, pkt_q;
  logic [ECC_W-1:0] ecc_q;
  logic             data_en_q, spare_en_q;

  seg_e             seg;
  logic [POS_W-1:0] pos, dcnt, didx, ecc_base;
  logic [ECC_W-1:0] scnt;
  logic             final_pkt, mark_done;

  // Named internal events
  logic beat_fire;
  logic map_last;

  pgl_cfg_hold #(.POS_W(POS_W), .ECC_W(ECC_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .start(start),
    .page_in(page_bytes), .pkt_in(pkt_bytes), .ecc_in(ecc_bytes),
    .data_en_in(data_en), .spare_en_in(spare_en),
    .page_q(page_q), .pkt_q(pkt_q), .ecc_q(ecc_q),
    .data_en_q(data_en_q), .spare_en_q(spare_en_q)
  );

  assign out_valid = (seg != SEG_IDLE);
  assign beat_fire = out_valid && out_ready;

  pgl_cursor #(.POS_W(POS_W), .ECC_W(ECC_W)) u_cursor (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(beat_fire),
    .page_len(page_q), .pkt_len(pkt_q), .ecc_len(ecc_q),
    .seg(seg), .pos(pos), .dcnt(dcnt), .didx(didx), .ecc_base(ecc_base),
    .scnt(scnt), .final_pkt(final_pkt), .mark_done(mark_done)
  );

  pgl_beat_map #(.POS_W(POS_W), .ECC_W(ECC_W)) u_map (
    .seg(seg), .didx(didx), .ecc_base(ecc_base), .scnt(scnt), .ecc_len(ecc_q),
    .final_pkt(final_pkt), .data_en(data_en_q), .spare_en(spare_en_q),
    .tag(out_tag), .idx(out_idx), .last(map_last)
  );

  assign out_pos  = pos;
  assign out_last = out_valid && map_last;

  // A refused beat is presented again unchanged
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !start |=>
      out_valid && $stable(out_pos) && $stable(out_idx) && $stable(out_tag));

  // Accepting the final byte ends the sequence
  assert_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire && out_last && !start |=> !out_valid);

  // A disabled data side never reports a data transfer
  assert_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !data_en_q |-> out_tag != TAG_DATA);

  // The last flag never stands on a data beat
  assert_last_spare_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_tag != TAG_DATA);

endmodule

// File: tb/sim_pgl_interleaver.sv
module sim_pgl_interleaver;

  localparam int POS_W = 16;
  localparam int ECC_W = 8;
  localparam int MAXB  = 1024;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [POS_W-1:0] page_bytes = '0;
  logic [POS_W-1:0] pkt_bytes = '0;
  logic [ECC_W-1:0] ecc_bytes = '0;
  logic             data_en = 1'b0;
  logic             spare_en = 1'b0;
  logic             out_ready = 1'b0;
  logic             out_valid;
  logic [POS_W-1:0] out_pos;
  logic [1:0]       out_tag;
  logic [POS_W-1:0] out_idx;
  logic             out_last;

  always #5 clk = ~clk;

  pgl_interleaver #(.POS_W(POS_W), .ECC_W(ECC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .page_bytes(page_bytes), .pkt_bytes(pkt_bytes), .ecc_bytes(ecc_bytes),
    .data_en(data_en), .spare_en(spare_en), .out_ready(out_ready),
    .out_valid(out_valid), .out_pos(out_pos), .out_tag(out_tag),
    .out_idx(out_idx), .out_last(out_last)
  );

  int    checks = 0;
  int    errors = 0;
  int    exp_tag [MAXB];
  int    exp_idx [MAXB];
  string exp_req [MAXB];
  int    exp_n;
  int    got_tag [MAXB];
  int    got_idx [MAXB];

  task automatic check_eq(input string req, input string what, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input bit is_data, input bit en, input int idx, input string req);
    exp_tag[exp_n] = !en ? 2 : (is_data ? 0 : 1);
    exp_idx[exp_n] = idx;
    exp_req[exp_n] = !en ? "R7" : req;
    exp_n++;
  endtask

  // Expected page walk: consume "remaining before offset" until a packet fits
  task automatic build(input int page, input int p, input int e, input bit den, input bit sen);
    int remain;
    int step;
    exp_n = 0;
    for (int i = 0; i < 4; i++) push(0, sen, 6 + i, "R2");
    remain = page;
    step = 0;
    while (remain > p) begin
      for (int j = 0; j < p; j++) push(1, den, step * p + j, "R3");
      for (int j = 0; j < e; j++) push(0, sen, 10 + step * e + j, "R3");
      step++;
      remain = page - exp_n;
    end
    for (int j = 0; j < remain; j++) push(1, den, step * p + j, "R5");
    for (int j = 0; j < 6; j++) push(0, sen, j, "R4");
    for (int j = remain; j < p; j++) push(1, den, step * p + j, "R5");
    for (int j = 0; j < e; j++) push(0, sen, 10 + step * e + j, "R5");
  endtask

  task automatic run_stream(input int page, input int p, input int e, input bit den,
                            input bit sen, input bit stall_mode, input bit scramble,
                            input int stop_after);
    int got;
    int cyc;
    bit stalled;
    int s_pos, s_tag, s_idx;
    @(negedge clk);
    page_bytes = POS_W'(page);
    pkt_bytes  = POS_W'(p);
    ecc_bytes  = ECC_W'(e);
    data_en    = den;
    spare_en   = sen;
    out_ready  = 1'b0;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin
      page_bytes = POS_W'(7);
      pkt_bytes  = POS_W'(3);
      ecc_bytes  = ECC_W'(1);
      data_en    = ~den;
      spare_en   = ~sen;
    end
    #1;
    check_eq("R1", "valid after start", int'(out_valid), 1);
    check_eq("R1", "first position", int'(out_pos), 0);
    got = 0;
    cyc = 0;
    stalled = 0;
    s_pos = 0; s_tag = 0; s_idx = 0;
    while (got < exp_n && got != stop_after && cyc < 5000) begin
      out_ready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (stalled) begin
        check_eq("R8", "valid held", int'(out_valid), 1);
        check_eq("R8", "pos held", int'(out_pos), s_pos);
        check_eq("R8", "tag held", int'(out_tag), s_tag);
        check_eq("R8", "idx held", int'(out_idx), s_idx);
        stalled = 0;
      end
      if (out_valid && out_ready) begin
        check_eq("R1", "position", int'(out_pos), got);
        check_eq(exp_req[got], "tag", int'(out_tag), exp_tag[got]);
        check_eq(exp_req[got], "index", int'(out_idx), exp_idx[got]);
        check_eq("R6", "last flag", int'(out_last), (got == exp_n - 1) ? 1 : 0);
        got_tag[got] = int'(out_tag);
        got_idx[got] = int'(out_idx);
        got++;
      end else if (out_valid) begin
        stalled = 1;
        s_pos = int'(out_pos);
        s_tag = int'(out_tag);
        s_idx = int'(out_idx);
      end
      @(negedge clk);
      cyc++;
    end
    if (stop_after < 0) begin
      out_ready = 1'b1;
      #1;
      check_eq("R6", "beat count", got, exp_n);
      check_eq("R6", "valid after last", int'(out_valid), 0);
      @(negedge clk);
      #1;
      check_eq("R6", "still idle", int'(out_valid), 0);
    end
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check_eq("R10", "valid in reset", int'(out_valid), 0);
    check_eq("R10", "last in reset", int'(out_last), 0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check_eq("R10", "valid before start", int'(out_valid), 0);
    check_eq("R10", "last before start", int'(out_last), 0);
    out_ready = 1'b0;
  endtask

  // 64/16/4: final packet begins right at the page offset
  task automatic t_offset_start;
    build(64, 16, 4, 1, 1);
    run_stream(64, 16, 4, 1, 1, 0, 0, -1);
    check_eq("R11", "marker first at offset", got_idx[64], 0);
    check_eq("R11", "marker tag at offset", got_tag[64], 1);
    check_eq("R5", "data after marker", got_idx[70], 48);
  endtask

  // 64/32/8 with stalls and inputs changed after start
  task automatic t_split_stall;
    build(64, 32, 8, 1, 1);
    run_stream(64, 32, 8, 1, 1, 1, 1, -1);
    check_eq("R5", "data before marker", got_idx[63], 51);
    check_eq("R4", "marker start", got_idx[64], 0);
    check_eq("R5", "data resumes", got_idx[70], 52);
    check_eq("R1", "captured cfg count", exp_n, 90);
  endtask

  // 32/8/2: final packet starts exactly one packet before the offset
  task automatic t_tight;
    build(32, 8, 2, 1, 1);
    run_stream(32, 8, 2, 1, 1, 0, 0, -1);
    check_eq("R11", "marker after full data", got_idx[32], 0);
    check_eq("R11", "ecc right after marker", got_idx[38], 14);
    check_eq("R11", "ecc tag after marker", got_tag[38], 1);
  endtask

  task automatic t_skip;
    build(64, 32, 8, 0, 1);
    run_stream(64, 32, 8, 0, 1, 0, 0, -1);
    check_eq("R7", "data skipped", got_tag[10], 2);
    build(64, 32, 8, 1, 0);
    run_stream(64, 32, 8, 1, 0, 1, 0, -1);
    check_eq("R7", "spare skipped", got_tag[0], 2);
    check_eq("R7", "data kept", got_tag[4], 0);
  endtask

  task automatic t_restart;
    build(64, 16, 4, 1, 1);
    run_stream(64, 16, 4, 1, 1, 0, 0, 10);
    build(32, 8, 2, 1, 1);
    run_stream(32, 8, 2, 1, 1, 0, 0, -1);
    check_eq("R9", "restart first index", got_idx[0], 6);
    check_eq("R9", "restart new ecc base", got_idx[12], 10);
  endtask

  int wd_cycles = 0;
  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd_cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_offset_start();
    t_split_stall();
    t_tight();
    t_skip();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule